// File: doc/BRIEF.md
# Tagged-Character UART Data Register Front End

This block is the register-side face of a UART. The character receiver hands it one byte at a time, together with a parity-error flag and the sampled stop-bit value. Each byte is stored in a receive queue together with its error tags. A processor read of the data register returns the oldest byte and removes it. A processor write appends a byte to a transmit queue, which feeds the character transmitter through a valid/ready handshake.

The error tags never appear in the read data. A separate set of status outputs shows the parity, framing and overrun tags of whichever entry currently sits at the head of the receive queue. When the receive queue is full, an arriving character is dropped. The entry stored most recently then gets its overrun tag set. Two level enables, one per direction, keep their queue empty while they are low.

Top module: `uart_dreg_front`

## Requirements
- R1: After reset both queues are empty: `bus_rdata` is 0, all three error status flags are 0, `stat_rx_ne` is 0, `tx_valid` is 0 and `stat_tx_nf` is 1.
- R2: Each receive entry is 11 bits: the byte in bits 7:0, the parity error in bit 8 (equal to `rx_par_err`), the framing error in bit 9 (1 when `rx_stop_bit` was 0) and overrun in bit 10 (0 when stored).
- R3: `bus_rdata` shows bits 7:0 of the oldest receive entry, and a `bus_rd` pulse removes that entry, so bytes come out in arrival order.
- R4: A character delivered while the receive queue holds RX_DEPTH entries is discarded and sets bit 10 of the newest stored entry. A pop in the same cycle does not make room for it.
- R5: `stat_par_err`, `stat_frm_err` and `stat_ovr` equal bits 8, 9 and 10 of the head receive entry, and are 0 while the receive queue is empty.
- R6: A `bus_rd` while the receive queue is empty returns 0 and changes no state.
- R7: A `bus_wr` appends `bus_wdata` to the transmit queue. `tx_byte` shows the oldest byte while `tx_valid` is 1, and that byte is removed on a cycle with `tx_valid` and `tx_ready` both 1.
- R8: A `bus_wr` while the transmit queue holds TX_DEPTH entries is ignored. A pop in the same cycle does not make room for it.
- R9: While `tx_en` is 0 the transmit queue is emptied and writes are ignored. While `rx_en` is 0 the receive queue is emptied and incoming characters are ignored.
- R10: `stat_rx_ne` is 1 exactly when the receive queue holds an entry. `stat_tx_nf` is 1 exactly when the transmit queue holds fewer than TX_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low keeps the receive queue empty |
| tx_en | input | 1 | Transmit enable; low keeps the transmit queue empty |
| rx_byte | input | 8 | Character from the receiver |
| rx_par_err | input | 1 | Parity error reported for `rx_byte` |
| rx_stop_bit | input | 1 | Sampled stop-bit value for `rx_byte` |
| rx_valid | input | 1 | Character delivery strobe |
| bus_rd | input | 1 | Read of the data register (pops the receive head) |
| bus_rdata | output | 8 | Byte of the receive head, 0 when empty |
| bus_wr | input | 1 | Write of the data register |
| bus_wdata | input | 8 | Byte to transmit |
| tx_byte | output | 8 | Oldest byte of the transmit queue |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_ready | input | 1 | Transmitter accepts `tx_byte` |
| stat_par_err | output | 1 | Parity tag of the receive head |
| stat_frm_err | output | 1 | Framing tag of the receive head |
| stat_ovr | output | 1 | Overrun tag of the receive head |
| stat_rx_ne | output | 1 | Receive queue not empty |
| stat_tx_nf | output | 1 | Transmit queue not full |

## Verification
A directed fill of the receive queue uses a distinct byte and a different parity/stop-bit mix for each entry. This separates a wrong bit order in the tags from a wrong queue order. Pushing two characters beyond capacity and then draining shows whether overrun lands on the newest stored entry, on the dropped one or on the head. A transmit fill past capacity with the transmitter stalled, followed by a drain, separates ignored writes from overwritten ones. A long random mix of deliveries, reads, writes, handshakes and brief enable drops exercises simultaneous push/pop at full and empty against a queue-based model.

// File: rtl/udr_pkg.sv
package udr_pkg;
   localparam int BYTE_W = 8;

   // bit 10 overrun, bit 9 framing, bit 8 parity, bits 7:0 character
   typedef struct packed {
      logic              ovr;
      logic              frm;
      logic              par;
      logic [BYTE_W-1:0] data;
   } rx_entry_t;

   localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/udr_fifo.sv
module udr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   input  logic         mark_last,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx, newest;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nx = wr_ptr + 1'b1;
         assign rd_nx = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nx = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         assign rd_nx = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign newest  = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
      if (mark_last && !empty && !flush) mem[newest][W-1] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nx;
         if (do_pop)  rd_ptr <= rd_nx;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/udr_rx_path.sv
module udr_rx_path
   import udr_pkg::*;
#(
   parameter int DEPTH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_par_err,
   input  logic              rx_stop_bit,
   input  logic              rx_valid,
   input  logic              pop,
   output rx_entry_t         head,
   output logic              not_empty
);
   rx_entry_t             entry_in;
   logic [ENTRY_W-1:0]    head_raw;
   logic                  empty, full, arrive;

   assign arrive   = rx_valid && en;
   assign entry_in = '{ovr: 1'b0, frm: !rx_stop_bit, par: rx_par_err, data: rx_byte};

   udr_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (!en),
      .push      (arrive),
      .din       (entry_in),
      .pop       (pop),
      .mark_last (arrive && full),
      .head      (head_raw),
      .empty     (empty),
      .full      (full)
   );

   assign head      = empty ? '0 : rx_entry_t'(head_raw);
   assign not_empty = !empty;
endmodule

// File: rtl/udr_tx_path.sv
module udr_tx_path
   import udr_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              ready,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_valid,
   output logic              not_full
);
   logic [BYTE_W-1:0] head_raw;
   logic              empty, full;

   udr_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (!en),
      .push      (wr),
      .din       (wdata),
      .pop       (ready),
      .mark_last (1'b0),
      .head      (head_raw),
      .empty     (empty),
      .full      (full)
   );

   assign tx_valid = !empty;
   assign tx_byte  = empty ? '0 : head_raw;
   assign not_full = !full;
endmodule

// File: rtl/uart_dreg_front.sv
module uart_dreg_front
   import udr_pkg::*;
#(
   parameter int RX_DEPTH = 12,
   parameter int TX_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_par_err,
   input  logic              rx_stop_bit,
   input  logic              rx_valid,
   input  logic              bus_rd,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              stat_par_err,
   output logic              stat_frm_err,
   output logic              stat_ovr,
   output logic              stat_rx_ne,
   output logic              stat_tx_nf
);
   generate
      if (RX_DEPTH < 2) begin : g_bad_rx
         $error("RX_DEPTH must be at least 2 so the newest entry is never the head when full");
      end
      if (TX_DEPTH < 1) begin : g_bad_tx
         $error("TX_DEPTH must be at least 1");
      end
   endgenerate

   rx_entry_t rx_head;

   udr_rx_path #(.DEPTH(RX_DEPTH)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (rx_en),
      .rx_byte     (rx_byte),
      .rx_par_err  (rx_par_err),
      .rx_stop_bit (rx_stop_bit),
      .rx_valid    (rx_valid),
      .pop         (bus_rd),
      .head        (rx_head),
      .not_empty   (stat_rx_ne)
   );

   udr_tx_path #(.DEPTH(TX_DEPTH)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (tx_en),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .ready    (tx_ready),
      .tx_byte  (tx_byte),
      .tx_valid (tx_valid),
      .not_full (stat_tx_nf)
   );

   // head tags are zero when the receive queue is empty (masked in u_rx)
   assign bus_rdata    = rx_head.data;
   assign stat_par_err = rx_head.par;
   assign stat_frm_err = rx_head.frm;
   assign stat_ovr     = rx_head.ovr;
endmodule

// File: rtl/udr_chk.sv
module udr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_en,
   input logic       tx_en,
   input logic       rx_valid,
   input logic       bus_rd,
   input logic [7:0] bus_rdata,
   input logic       bus_wr,
   input logic [7:0] tx_byte,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       stat_par_err,
   input logic       stat_frm_err,
   input logic       stat_ovr,
   input logic       stat_rx_ne,
   input logic       stat_tx_nf
);
   p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!stat_rx_ne && !tx_valid && stat_tx_nf));

   p_empty_tags_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rx_ne |-> !(stat_par_err || stat_frm_err || stat_ovr));

   p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rx_ne |-> (bus_rdata == 8'h00));

   p_empty_read_nochange_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rx_ne && !(rx_valid && rx_en)) |=> !stat_rx_ne);

   p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && tx_en) |=> (tx_valid && $stable(tx_byte)));

   p_tx_full_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_tx_nf && !(tx_valid && tx_ready) && tx_en) |=> !stat_tx_nf);

   p_rx_disable_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !stat_rx_ne);

   p_tx_disable_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!tx_valid && stat_tx_nf));
endmodule

bind uart_dreg_front udr_chk u_chk (.*);

// File: tb/uart_dreg_front_tb.sv
module uart_dreg_front_tb;
   localparam int RXD = 12;
   localparam int TXD = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b1, tx_en = 1'b1;
   logic [7:0] rx_byte = '0;
   logic       rx_par_err = 1'b0, rx_stop_bit = 1'b1, rx_valid = 1'b0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0, tx_ready = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata, tx_byte;
   logic       tx_valid, stat_par_err, stat_frm_err, stat_ovr, stat_rx_ne, stat_tx_nf;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   logic [10:0] rxq[$];
   logic [7:0]  txq[$];

   always #4 clk = ~clk;   // 125 MHz

   uart_dreg_front #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
      .rx_byte(rx_byte), .rx_par_err(rx_par_err), .rx_stop_bit(rx_stop_bit),
      .rx_valid(rx_valid), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .tx_byte(tx_byte),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .stat_par_err(stat_par_err),
      .stat_frm_err(stat_frm_err), .stat_ovr(stat_ovr),
      .stat_rx_ne(stat_rx_ne), .stat_tx_nf(stat_tx_nf));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
      end
   endtask

   // reference model: next state from current queues and inputs
   task automatic model_step();
      bit rx_full, tx_full;
      if (!rx_en) rxq.delete();
      else begin
         rx_full = (rxq.size() == RXD);
         if (bus_rd && rxq.size() > 0) void'(rxq.pop_front());
         if (rx_valid) begin
            if (!rx_full) rxq.push_back({1'b0, ~rx_stop_bit, rx_par_err, rx_byte});
            else rxq[rxq.size()-1][10] = 1'b1;
         end
      end
      if (!tx_en) txq.delete();
      else begin
         tx_full = (txq.size() == TXD);
         if (tx_ready && txq.size() > 0) void'(txq.pop_front());
         if (bus_wr && !tx_full) txq.push_back(bus_wdata);
      end
   endtask

   task automatic compare();
      string rtag, ttag;
      if (!rx_en) rtag = "R9";
      else if (rxq.size() == 0) rtag = "R6";
      else rtag = "R3";
      chk(rtag, 32'(bus_rdata), rxq.size() ? 32'(rxq[0][7:0]) : 0);
      chk("R10", 32'(stat_rx_ne), 32'(rxq.size() > 0));
      chk("R2 R5 parity", 32'(stat_par_err), rxq.size() ? 32'(rxq[0][8]) : 0);
      chk("R2 R5 framing", 32'(stat_frm_err), rxq.size() ? 32'(rxq[0][9]) : 0);
      chk("R4 R5 overrun", 32'(stat_ovr), rxq.size() ? 32'(rxq[0][10]) : 0);
      if (!tx_en) ttag = "R9";
      else if (txq.size() == TXD) ttag = "R8";
      else ttag = "R7";
      chk(ttag, 32'(tx_valid), 32'(txq.size() > 0));
      if (txq.size() > 0) chk(ttag, 32'(tx_byte), 32'(txq[0]));
      chk("R10 R8", 32'(stat_tx_nf), 32'(txq.size() < TXD));
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      cycles++;
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      rx_valid = 0; bus_rd = 0; bus_wr = 0; tx_ready = 0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 rdata", 32'(bus_rdata), 0);
      chk("R1 rx_ne", 32'(stat_rx_ne), 0);
      chk("R1 tags", 32'({stat_par_err, stat_frm_err, stat_ovr}), 0);
      chk("R1 tx_valid", 32'(tx_valid), 0);
      chk("R1 tx_nf", 32'(stat_tx_nf), 1);

      // R6: read on empty
      bus_rd = 1; cyc(); idle(); cyc();

      // R2 R4: fill receive queue past capacity with varied tags
      for (int i = 0; i < RXD + 2; i++) begin
         rx_valid = 1; rx_byte = 8'(8'h30 + i);
         rx_par_err = i[0]; rx_stop_bit = ~i[1];
         cyc();
      end
      idle();
      // R4: full + arrival + same-cycle pop still drops
      rx_valid = 1; bus_rd = 1; rx_byte = 8'hEE; cyc(); idle();
      // R3 R5: drain
      for (int i = 0; i < RXD + 2; i++) begin
         bus_rd = 1; cyc();
      end
      idle();

      // R7 R8: transmit fill past capacity with stalled transmitter
      for (int i = 0; i < TXD + 3; i++) begin
         bus_wr = 1; bus_wdata = 8'(8'hA0 + i); cyc();
      end
      bus_wr = 1; tx_ready = 1; bus_wdata = 8'h5A; cyc();   // R8: full, pop same cycle
      idle();
      for (int i = 0; i < TXD + 2; i++) begin
         tx_ready = 1; cyc();
      end
      idle();

      // R9: enables low flush and ignore
      for (int i = 0; i < 4; i++) begin
         rx_valid = 1; rx_byte = 8'(i); bus_wr = 1; bus_wdata = 8'(i); cyc();
      end
      rx_en = 0; tx_en = 0; cyc(); cyc();
      rx_en = 1; tx_en = 1; idle(); cyc();

      // random mix
      for (int i = 0; i < 6000; i++) begin
         rx_valid    = ($urandom_range(0, 9) < 5);
         rx_byte     = 8'($urandom);
         rx_par_err  = ($urandom_range(0, 3) == 0);
         rx_stop_bit = ($urandom_range(0, 3) != 0);
         bus_rd      = ($urandom_range(0, 9) < 3);
         bus_wr      = ($urandom_range(0, 9) < 4);
         bus_wdata   = 8'($urandom);
         tx_ready    = ($urandom_range(0, 9) < 3);
         rx_en       = ($urandom_range(0, 99) != 0);
         tx_en       = ($urandom_range(0, 99) != 0);
         cyc();
      end
      finish_run();
   end
endmodule